// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Window Check

This block is the digital half of a 10-bit successive-approximation converter. It drives the code of an external DAC, a sample/hold control, an amplifier enable, a settle-assist strobe and an active-low precharge for the comparator latch. It reads back one comparator bit per step. The comparator bit is high when the DAC level is above the analog input.

Two jobs can be started. A conversion samples for two clocks and then runs a ten-step binary search, most significant bit first. A window check samples the same way and then applies only two codes, a lower and an upper limit. It reports pass when the comparator is low at the lower code and high at the upper code, which means lower <= input < upper. Each time the block is enabled it first runs a throw-away conversion so that the analog path can settle. That conversion publishes nothing, and a start request is accepted only when the block is idle.

Top module: `sar_seq_top`

## Requirements
- R1: In conversion mode (mode input 0) an accepted start produces, 22 clocks after the accepting edge, done high and a result equal to the largest code at which the comparator read low. Done is low at 21 clocks.
- R2: When enable rises, the block runs one dummy conversion. It raises neither done nor pass, leaves the result unchanged, and ignores start requests until it ends 22 clocks after the enable edge.
- R3: HOLD stays low for exactly the first two clocks after an accepted start. Whenever HOLD is low, the DAC code is 0x200.
- R4: The first comparison step of a conversion drives the DAC with only bit 9 set (0x200). Each step clears its trial bit if the comparator is high, keeps it otherwise, and sets the next lower bit.
- R5: In window mode (mode input 1) the DAC carries the lower code in the first step and the upper code in the second. Six clocks after the accepting edge, done is high and pass equals (comparator low at lower) AND (comparator high at upper). The conversion result is left unchanged.
- R6: Amplifier enable follows enable one clock later. Settle-assist is high for exactly the first two clocks after amplifier enable rises and low afterwards.
- R7: Each comparison step is two clocks long. Precharge (active low) is low in its first clock and high in its second, and it is low only while HOLD is high.
- R8: A start request while a conversion or window check is running is ignored. The running job finishes on its original schedule with its original result.
- R9: On the first edge with enable low, the block goes idle: done and pass go low, HOLD goes low, the DAC returns to 0x200 and amplifier enable drops.
- R10: Done and pass hold their values while the block is idle, until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| start_i | input | 1 | Start request, sampled when idle |
| win_mode_i | input | 1 | 0 = conversion, 1 = window check |
| lo_code_i | input | 10 | Lower limit code for the window check |
| hi_code_i | input | 10 | Upper limit code for the window check |
| cmp_i | input | 1 | Comparator bit, high when the DAC level is above the input |
| dac_o | output | 10 | Code driven to the DAC |
| hold_o | output | 1 | Sample/hold control, low = sampling |
| amp_en_o | output | 1 | Amplifier enable |
| settle_o | output | 1 | Settle-assist strobe |
| prech_n_o | output | 1 | Comparator precharge, active low |
| result_o | output | 10 | Last conversion result |
| done_o | output | 1 | Job finished |
| win_pass_o | output | 1 | Window check passed |

## Verification
Counting from the edge that accepts a start, the sampling window covers the clocks after edges 0 and 1, step k has precharge after edge 2+2k and compare after edge 3+2k, and the comparator is captured on edge 4+2k. This puts a conversion result at edge 22 and a window verdict at edge 6. The bench drives inputs on the falling edge, counts rising edges from the accepting one and samples 1 ns after the edge under test. It also checks one clock earlier that done is still low, so a result that arrives early or late is caught. For settle-assist and the enable/disable reactions, the same counting runs from the falling edge that changes enable.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_PRE    = 2'd2,
    ST_CMP    = 2'd3
  } sar_state_e;

  // Next value of one trial bit in the binary search.
  // at_bit:   this bit is the one under test in the current step.
  // at_above: the bit just above is under test, so this bit becomes the next trial.
  // cmp_high: comparator reports the DAC above the input.
  function automatic logic trial_bit_next(input logic cur, input logic load,
                                          input logic load_val, input logic at_bit,
                                          input logic at_above, input logic cmp_high);
    if (load)          return load_val;
    else if (at_bit)   return ~cmp_high;
    else if (at_above) return 1'b1;
    else               return cur;
  endfunction

  // Window verdict: the input must lie at or above the lower code and below the upper one.
  function automatic logic window_verdict(input logic cmp_at_lo, input logic cmp_at_hi);
    return (~cmp_at_lo) & cmp_at_hi;
  endfunction

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int DAC_W      = 10,
  parameter int SAMPLE_CYC = 2,
  parameter int STEP_W     = $clog2(DAC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              win_mode_i,
  output sar_state_e        state_o,
  output logic [STEP_W-1:0] step_o,
  output logic              win_o,
  output logic              dummy_o,
  output logic              en_q_o,
  output logic              begin_dummy_o,
  output logic              accept_o,
  output logic              load_ev_o,
  output logic              sample_ev_o,
  output logic              finish_ev_o
);
  localparam int SC_W = $clog2(SAMPLE_CYC) + 1;
  localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(DAC_W - 1);
  localparam logic [STEP_W-1:0] WIN_STEP = STEP_W'(1);

  sar_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [SC_W-1:0]   samp_cnt_q;
  logic              win_q, dummy_q, en_q;

  // Named events for the datapath and the assertions.
  logic begin_dummy, accept, sample_ev, finish_ev;
  assign begin_dummy = en_i & ~en_q;
  assign accept      = en_i & en_q & (state_q == ST_IDLE) & start_i;
  assign sample_ev   = en_i & (state_q == ST_CMP);
  assign finish_ev   = sample_ev & (step_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      samp_cnt_q <= '0;
      win_q      <= 1'b0;
      dummy_q    <= 1'b0;
      en_q       <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      dummy_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      en_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (begin_dummy) begin
            state_q    <= ST_SAMPLE;
            dummy_q    <= 1'b1;
            win_q      <= 1'b0;
            step_q     <= TOP_STEP;
            samp_cnt_q <= SC_W'(SAMPLE_CYC - 1);
          end else if (accept) begin
            state_q    <= ST_SAMPLE;
            dummy_q    <= 1'b0;
            win_q      <= win_mode_i;
            step_q     <= win_mode_i ? WIN_STEP : TOP_STEP;
            samp_cnt_q <= SC_W'(SAMPLE_CYC - 1);
          end
        end
        ST_SAMPLE: begin
          if (samp_cnt_q == '0) state_q <= ST_PRE;
          else                  samp_cnt_q <= samp_cnt_q - 1'b1;
        end
        ST_PRE: state_q <= ST_CMP;
        ST_CMP: begin
          if (step_q == '0) begin
            state_q <= ST_IDLE;
            dummy_q <= 1'b0;
          end else begin
            step_q  <= step_q - 1'b1;
            state_q <= ST_PRE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o       = state_q;
  assign step_o        = step_q;
  assign win_o         = win_q;
  assign dummy_o       = dummy_q;
  assign en_q_o        = en_q;
  assign begin_dummy_o = begin_dummy;
  assign accept_o      = accept;
  assign load_ev_o     = begin_dummy | accept;
  assign sample_ev_o   = sample_ev;
  assign finish_ev_o   = finish_ev;

  // R8: a start while busy never disturbs the step sequence.
  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && state_q == ST_CMP && step_q != '0) |=> (state_q == ST_PRE || !en_q));

  // R2: a start request during the dummy run is never accepted.
  assert_dummy_no_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy_q && state_q != ST_IDLE) |-> !accept);

  // R7: precharge step is always followed by the compare step while enabled.
  assert_pre_then_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && en_i) |=> state_q == ST_CMP);

endmodule

// File: rtl/sar_trial.sv
module sar_trial
  import sar_pkg::*;
#(
  parameter int DAC_W  = 10,
  parameter int STEP_W = $clog2(DAC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev_i,
  input  logic              sample_ev_i,
  input  logic              finish_ev_i,
  input  logic              win_i,
  input  logic              dummy_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              cmp_i,
  output logic [DAC_W-1:0]  trial_o,
  output logic [DAC_W-1:0]  result_o
);
  logic [DAC_W-1:0] trial_q, trial_nx, result_q;
  logic             search_ev, publish_ev;

  assign search_ev  = sample_ev_i & ~win_i;
  assign publish_ev = finish_ev_i & ~win_i & ~dummy_i;

  for (genvar i = 0; i < DAC_W; i++) begin : g_bit
    logic at_bit, at_above;
    assign at_bit = search_ev & (step_i == STEP_W'(i));
    if (i == DAC_W - 1) begin : g_top
      assign at_above = 1'b0;
    end else begin : g_low
      assign at_above = search_ev & (step_i == STEP_W'(i + 1));
    end
    assign trial_nx[i] = trial_bit_next(trial_q[i], load_ev_i, (i == DAC_W - 1),
                                        at_bit, at_above, cmp_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q  <= {1'b1, {(DAC_W-1){1'b0}}};
      result_q <= '0;
    end else begin
      trial_q <= trial_nx;
      if (publish_ev) result_q <= trial_nx;
    end
  end

  assign trial_o  = trial_q;
  assign result_o = result_q;

  // R1: a published result keeps all bits above bit 0 that were decided earlier.
  assert_result_upper_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    publish_ev |=> result_q[DAC_W-1:1] == $past(trial_q[DAC_W-1:1]));

  // R4: a fresh job starts the search from the midpoint code.
  assert_search_from_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev_i |=> trial_q == {1'b1, {(DAC_W-1){1'b0}}});

endmodule

// File: rtl/sar_window.sv
module sar_window
  import sar_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              accept_i,
  input  logic              sample_ev_i,
  input  logic              finish_ev_i,
  input  logic              win_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              cmp_i,
  output logic              pass_o
);
  logic lo_cmp_q, pass_q;
  logic lo_capture, verdict_ev;

  assign lo_capture = sample_ev_i & win_i & (step_i == STEP_W'(1));
  assign verdict_ev = finish_ev_i & win_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cmp_q <= 1'b0;
      pass_q   <= 1'b0;
    end else if (!en_i || accept_i) begin
      pass_q <= 1'b0;
    end else begin
      if (lo_capture) lo_cmp_q <= cmp_i;
      if (verdict_ev) pass_q   <= window_verdict(lo_cmp_q, cmp_i);
    end
  end

  assign pass_o = pass_q;

  // R5: pass can only rise on the window verdict edge.
  assert_pass_only_on_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_q) |-> $past(verdict_ev));

endmodule

// File: rtl/sar_settle.sv
module sar_settle #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic rise_i,
  output logic settle_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (rise_i)       cnt_q <= CW'(SETTLE_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign settle_o = (cnt_q != '0);

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int DAC_W      = 10,
  parameter int SAMPLE_CYC = 2,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             win_mode_i,
  input  logic [DAC_W-1:0] lo_code_i,
  input  logic [DAC_W-1:0] hi_code_i,
  input  logic             cmp_i,
  output logic [DAC_W-1:0] dac_o,
  output logic             hold_o,
  output logic             amp_en_o,
  output logic             settle_o,
  output logic             prech_n_o,
  output logic [DAC_W-1:0] result_o,
  output logic             done_o,
  output logic             win_pass_o
);
  localparam int STEP_W = $clog2(DAC_W);
  localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

  sar_state_e        state;
  logic [STEP_W-1:0] step;
  logic              win, dummy, en_q, begin_dummy, accept;
  logic              load_ev, sample_ev, finish_ev;
  logic [DAC_W-1:0]  trial, lo_q, hi_q;
  logic              done_q, in_step;

  sar_ctrl #(.DAC_W(DAC_W), .SAMPLE_CYC(SAMPLE_CYC), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i), .win_mode_i(win_mode_i),
    .state_o(state), .step_o(step), .win_o(win), .dummy_o(dummy), .en_q_o(en_q),
    .begin_dummy_o(begin_dummy), .accept_o(accept), .load_ev_o(load_ev),
    .sample_ev_o(sample_ev), .finish_ev_o(finish_ev)
  );

  sar_trial #(.DAC_W(DAC_W), .STEP_W(STEP_W)) u_trial (
    .clk(clk), .rst_n(rst_n), .load_ev_i(load_ev), .sample_ev_i(sample_ev),
    .finish_ev_i(finish_ev), .win_i(win), .dummy_i(dummy), .step_i(step),
    .cmp_i(cmp_i), .trial_o(trial), .result_o(result_o)
  );

  sar_window #(.STEP_W(STEP_W)) u_window (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .accept_i(accept), .sample_ev_i(sample_ev),
    .finish_ev_i(finish_ev), .win_i(win), .step_i(step), .cmp_i(cmp_i),
    .pass_o(win_pass_o)
  );

  sar_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .rise_i(begin_dummy), .settle_o(settle_o)
  );

  // Limits are frozen at the accepting edge so the two window steps see one pair.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (accept) begin
      lo_q <= lo_code_i;
      hi_q <= hi_code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       done_q <= 1'b0;
    else if (!en_i || accept)         done_q <= 1'b0;
    else if (finish_ev && !dummy)     done_q <= 1'b1;
  end

  assign in_step = (state == ST_PRE) || (state == ST_CMP);

  always_comb begin
    if (!in_step)              dac_o = MID;
    else if (!win)             dac_o = trial;
    else if (step == STEP_W'(1)) dac_o = lo_q;
    else                       dac_o = hi_q;
  end

  assign hold_o    = in_step;
  assign prech_n_o = ~(state == ST_PRE);
  assign amp_en_o  = en_q;
  assign done_o    = done_q;

  // R3: while sampling the DAC sits at midpoint.
  assert_mid_while_sampling_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_o |-> dac_o == MID);

  // R6: settle-assist starts with amplifier enable and lasts no more than two clocks.
  assert_settle_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_en_o) |-> settle_o);
  assert_settle_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_o && $past(settle_o)) |=> !settle_o);
  assert_settle_needs_amp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    settle_o |-> amp_en_o);

  // R7: precharge is a single clock and only inside a hold phase.
  assert_prech_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !prech_n_o |-> hold_o);
  assert_prech_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !prech_n_o |=> prech_n_o);

  // R5: pass is only reported together with done.
  assert_pass_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_pass_o |-> done_o);

  // R9: after an edge with enable low nothing is reported or held.
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> (!done_o && !win_pass_o && !hold_o && !amp_en_o));

  // R2: the dummy run never raises done.
  assert_dummy_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_ev && dummy) |=> !done_o);

endmodule

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;
  localparam int W = 10;
  localparam int MIDC = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, start = 1'b0, win_mode = 1'b0;
  logic [W-1:0] lo_code = '0, hi_code = '0;
  logic [W:0]   vin = '0;
  logic         cmp;
  logic [W-1:0] dac, result;
  logic hold, amp_en, settle, prech_n, done, pass;

  int checks = 0;
  int fails = 0;
  int last_result = 0;

  always #2 clk = ~clk;  // 250 MHz

  // Comparator model: high when the DAC level is above the input.
  assign cmp = ({1'b0, dac} > vin);

  sar_seq_top i_sar_seq_top (
    .clk(clk), .rst_n(rst_n), .en_i(en), .start_i(start), .win_mode_i(win_mode),
    .lo_code_i(lo_code), .hi_code_i(hi_code), .cmp_i(cmp),
    .dac_o(dac), .hold_o(hold), .amp_en_o(amp_en), .settle_o(settle),
    .prech_n_o(prech_n), .result_o(result), .done_o(done), .win_pass_o(pass)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic edge_after();
    @(posedge clk);
    #1;
  endtask

  // Conversion; extra start pulses during the run when poke is set.
  task automatic run_conv(input int v, input bit detail, input bit poke);
    @(negedge clk);
    vin = (W+1)'(v);
    win_mode = 1'b0;
    start = 1'b1;
    edge_after();                 // edge 0 accepts
    start = 1'b0;
    if (detail) begin
      chk(hold == 1'b0 && dac == W'(MIDC), "R3", "sample clk1 hold/dac", int'(dac), MIDC);
      chk(done == 1'b0, "R10", "done cleared at start", int'(done), 0);
    end
    edge_after();                 // edge 1
    if (detail) chk(hold == 1'b0 && dac == W'(MIDC), "R3", "sample clk2 hold/dac", int'(dac), MIDC);
    edge_after();                 // edge 2: first precharge
    if (detail) begin
      chk(hold == 1'b1, "R3", "hold rises after two clocks", int'(hold), 1);
      chk(dac == W'(MIDC), "R4", "first trial code", int'(dac), MIDC);
      chk(prech_n == 1'b0, "R7", "precharge low first clk of step", int'(prech_n), 0);
    end
    if (poke) begin @(negedge clk); start = 1'b1; end
    edge_after();                 // edge 3: compare clock
    start = 1'b0;
    if (detail) chk(prech_n == 1'b1, "R7", "precharge high in compare clk", int'(prech_n), 1);
    for (int e = 4; e <= 21; e++) begin
      if (poke && e == 13) begin @(negedge clk); start = 1'b1; end
      edge_after();
      start = 1'b0;
    end
    chk(done == 1'b0, "R1", "done not early (edge 21)", int'(done), 0);
    edge_after();                 // edge 22
    chk(done == 1'b1, poke ? "R8" : "R1", "done at edge 22", int'(done), 1);
    chk(int'(result) == v, poke ? "R8" : "R1", "conversion result", int'(result), v);
    last_result = v;
  endtask

  task automatic run_win(input int lo, input int hi, input int v, input bit detail);
    bit exp_pass;
    exp_pass = (v >= lo) && (v < hi);
    @(negedge clk);
    vin = (W+1)'(v);
    lo_code = W'(lo);
    hi_code = W'(hi);
    win_mode = 1'b1;
    start = 1'b1;
    edge_after();                 // edge 0
    start = 1'b0;
    win_mode = 1'b0;
    edge_after();                 // edge 1
    edge_after();                 // edge 2
    if (detail) chk(int'(dac) == lo, "R5", "lower code applied", int'(dac), lo);
    edge_after();                 // edge 3
    edge_after();                 // edge 4
    if (detail) chk(int'(dac) == hi, "R5", "upper code applied", int'(dac), hi);
    edge_after();                 // edge 5
    chk(done == 1'b0, "R5", "window done not early", int'(done), 0);
    edge_after();                 // edge 6
    chk(done == 1'b1, "R5", "window done", int'(done), 1);
    chk(pass == exp_pass, "R5", "window pass", int'(pass), int'(exp_pass));
    chk(int'(result) == last_result, "R5", "result untouched by window", int'(result), last_result);
  endtask

  task automatic enable_and_check(input bit detail);
    @(negedge clk);
    en = 1'b1;
    edge_after();                 // edge 0
    if (detail) chk(amp_en == 1'b1 && settle == 1'b1, "R6", "settle clk1", int'(settle), 1);
    edge_after();
    if (detail) chk(settle == 1'b1, "R6", "settle clk2", int'(settle), 1);
    edge_after();
    if (detail) chk(settle == 1'b0, "R6", "settle drops", int'(settle), 0);
    @(negedge clk);
    start = 1'b1;                 // ignored: dummy is running
    edge_after();
    start = 1'b0;
    for (int e = 4; e <= 30; e++) edge_after();
    chk(done == 1'b0 && pass == 1'b0, "R2", "dummy raises no done", int'(done), 0);
    chk(int'(result) == last_result, "R2", "dummy leaves result", int'(result), last_result);
    chk(hold == 1'b0, "R2", "idle after dummy, start ignored", int'(hold), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    edge_after();
    chk(done == 0 && pass == 0 && hold == 0 && amp_en == 0 && settle == 0 && prech_n == 1,
        "R9", "reset idle outputs", int'(done), 0);
    chk(dac == W'(MIDC) && result == '0, "R3", "reset dac midpoint", int'(dac), MIDC);

    enable_and_check(1'b1);

    // Exhaustive conversion sweep.
    for (int v = 0; v < (1 << W); v++) run_conv(v, (v % 128) == 0, 1'b0);

    // Done persists while idle.
    repeat (5) edge_after();
    chk(done == 1'b1 && int'(result) == last_result, "R10", "done held while idle",
        int'(done), 1);

    // Starts during a running conversion are ignored.
    run_conv(777, 1'b1, 1'b1);
    run_conv(3, 1'b0, 1'b1);

    // Window sweeps over several limit pairs.
    for (int v = 0; v < (1 << W); v += 5) run_win(100, 900, v, v == 0);
    for (int v = 0; v < (1 << W); v += 5) run_win(0, 1023, v, 1'b0);
    for (int v = 505; v < 520; v++)       run_win(512, 513, v, v == 512);
    for (int v = 0; v < (1 << W); v += 37) run_win(700, 300, v, 1'b0);

    // Leave a pass standing, then disable.
    run_win(100, 900, 400, 1'b0);
    repeat (3) edge_after();
    chk(pass == 1'b1 && done == 1'b1, "R10", "pass held while idle", int'(pass), 1);
    @(negedge clk);
    en = 1'b0;
    edge_after();
    chk(done == 1'b0 && pass == 1'b0, "R9", "disable clears done/pass", int'(pass), 0);
    chk(amp_en == 1'b0 && hold == 1'b0 && dac == W'(MIDC), "R9", "disable idles outputs",
        int'(dac), MIDC);

    // Disable in the middle of a conversion.
    enable_and_check(1'b0);
    @(negedge clk);
    vin = 11'd600;
    start = 1'b1;
    edge_after();
    start = 1'b0;
    repeat (7) edge_after();
    chk(hold == 1'b1, "R9", "mid-run before disable", int'(hold), 1);
    @(negedge clk);
    en = 1'b0;
    edge_after();
    chk(hold == 1'b0 && dac == W'(MIDC) && done == 1'b0, "R9", "mid-run disable",
        int'(dac), MIDC);
    chk(int'(result) == last_result, "R9", "aborted run publishes nothing", int'(result),
        last_result);

    // Re-enable: dummy again, then a working conversion.
    enable_and_check(1'b1);
    run_conv(1023, 1'b1, 1'b0);
    run_conv(0, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule